// File: doc/BRIEF.md
# I/O Request to Wishbone Burst Master

This block turns one already-decoded inbound I/O request into Wishbone classic master cycles on a 64-bit bus with eight byte-select lines. A request is a read, a write that asks for a completion, or a write that asks for none. Each request carries a 4-bit size code, a word-pointer bit, a doubleword address, a transaction tag and two endpoint identifiers. The size code and word pointer together fix both the number of doubleword beats and the byte lanes used on every beat.

Write payload comes from an external doubleword queue: the head word is driven onto the bus, and the block pulses a pop strobe once per acknowledged write beat. Read data leaves the block one doubleword per acknowledged beat on a data strobe. A completion record (status, tag, swapped identifiers, data count) is issued at the end of each read and each write that asked for one, for an outbound frame writer to assemble. A new request is taken only while the block is idle.

Top module: `ioreq_wb_master`

## Requirements
- R1: Beat count: size codes 0 to 10 give 1 beat; code 11 gives 1 beat with pointer 0 and 2 with pointer 1; codes 12, 13, 14 and 15 give 4, 12, 20 and 28 beats with pointer 0 and 8, 16, 24 and 32 with pointer 1.
- R2: Single-byte codes 0 to 3 drive a one-hot `wb_sel` equal to 8'h80 shifted right by the code when the pointer is 0, and 8'h08 shifted right by the code when it is 1.
- R3: Multi-byte lanes (pointer 0 / 1): code 4 gives C0/0C, code 6 30/03, code 5 E0/07, code 8 F0/0F, code 7 F8/1F, code 9 FC/3F, code 10 FE/7F (hex); codes 11 to 15 give FF.
- R4: Beat k of a burst uses address base+k, and every beat uses the same `wb_sel` and `wb_we`.
- R5: `wb_stb` is only high with `wb_cyc`; it stays high with address, lanes and direction unchanged until ACK or ERR; `wb_cyc` stays high between beats and drops the cycle after the last ACK.
- R6: A read (`req_write`=0) ends with one `rsp_valid` pulse carrying status 0000, the request tag, `rsp_src` equal to the request destination, `rsp_dst` equal to the request source, and `rsp_len` equal to the beat count; each read doubleword appears on `rsp_data` with `rsp_data_valid`, in beat order, the cycle after its ACK.
- R7: A write with `req_want_rsp`=1 ends with one `rsp_valid` pulse carrying status 0000, the request tag, swapped identifiers and `rsp_len` 0, and no `rsp_data_valid` pulse.
- R8: A write with `req_want_rsp`=0 produces no `rsp_valid` pulse.
- R9: ERR abandons the burst: `wb_cyc` drops the next cycle and no further beat is issued; the response, where one is due, carries status 0111 and, for reads, a count of only the beats acknowledged before ERR.
- R10: `req_ready` is low from the cycle after acceptance until the burst ends; `req_valid` seen while it is low is ignored.
- R11: After reset `req_ready` is 1 and `wb_cyc`, `wb_stb`, `rsp_valid`, `rsp_data_valid` and `pay_next` are 0.
- R12: On write beat k `wb_dat_o` carries the k-th payload word, and `pay_next` pulses once per acknowledged write beat, the cycle after its ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_write | input | 1 | 1 write, 0 read |
| req_want_rsp | input | 1 | Write asks for a completion (ignored for reads) |
| req_size | input | 4 | Size code |
| req_wptr | input | 1 | Word pointer |
| req_adr | input | 31 | Doubleword start address |
| req_tid | input | 8 | Transaction tag |
| req_src | input | 16 | Requester identifier |
| req_dst | input | 16 | Target identifier |
| pay_data | input | 64 | Head word of the write payload queue |
| pay_next | output | 1 | Pop strobe for the payload queue |
| wb_cyc | output | 1 | Bus cycle |
| wb_stb | output | 1 | Beat strobe |
| wb_we | output | 1 | Write enable |
| wb_adr | output | 31 | Doubleword address |
| wb_sel | output | 8 | Byte lanes, bit 7 the first lane |
| wb_dat_o | output | 64 | Write data |
| wb_dat_i | input | 64 | Read data |
| wb_ack | input | 1 | Beat acknowledge |
| wb_err | input | 1 | Beat error |
| rsp_valid | output | 1 | Completion record strobe |
| rsp_status | output | 4 | 0000 done, 0111 error |
| rsp_tid | output | 8 | Echoed tag |
| rsp_src | output | 16 | Completion source (request target) |
| rsp_dst | output | 16 | Completion destination (request source) |
| rsp_len | output | 6 | Doublewords of read data delivered |
| rsp_data_valid | output | 1 | Read data strobe |
| rsp_data | output | 64 | Read doubleword |

## Verification
The request is taken on edge E0 and the first strobe is visible in the following cycle; every ACK or ERR seen at an edge is followed in the next cycle by the dropped strobe, the stepped address, the payload pop and, for reads, the data strobe. The completion record and the return of `req_ready` share the cycle after the final ACK or ERR, so the bench waits for `req_ready` at a falling edge and reads the record there. Beats and read words are checked as they occur at falling edges against the address, lanes and data computed from the size code, and the counts are compared one cycle after completion, when no further event can arrive.

// File: rtl/ioreq_pkg.sv
package ioreq_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_BEAT = 2'd1,
    ENG_GAP  = 2'd2
  } eng_state_t;

  localparam logic [3:0] RSP_OK   = 4'b0000;
  localparam logic [3:0] RSP_FAIL = 4'b0111;

  localparam int BYTES_PER_BEAT = 8;

endpackage

// File: rtl/ioreq_size_decode.sv
module ioreq_size_decode #(
  parameter int LANES = 8,
  parameter int CW    = 6
) (
  input  logic [3:0]       size_code,
  input  logic             wptr,
  output logic [CW-1:0]    beats,
  output logic [LANES-1:0] lanes
);

  localparam int LW = $clog2(LANES);

  logic [LW-1:0] first_lane;
  logic [LW-1:0] last_lane;

  // Lane window, counted from the most significant select bit.
  always_comb begin
    first_lane = '0;
    last_lane  = LW'(LANES - 1);
    if (!wptr) begin
      unique case (size_code)
        4'd0, 4'd1, 4'd2, 4'd3: begin
          first_lane = LW'(size_code);
          last_lane  = LW'(size_code);
        end
        4'd4:  last_lane = LW'(1);
        4'd6:  begin first_lane = LW'(2); last_lane = LW'(3); end
        4'd5:  last_lane = LW'(2);
        4'd8:  last_lane = LW'(3);
        4'd7:  last_lane = LW'(4);
        4'd9:  last_lane = LW'(5);
        4'd10: last_lane = LW'(6);
        default: ;
      endcase
    end else begin
      unique case (size_code)
        4'd0, 4'd1, 4'd2, 4'd3: begin
          first_lane = LW'(size_code + 4'd4);
          last_lane  = LW'(size_code + 4'd4);
        end
        4'd4:  begin first_lane = LW'(4); last_lane = LW'(5); end
        4'd6:  first_lane = LW'(6);
        4'd5:  first_lane = LW'(5);
        4'd8:  first_lane = LW'(4);
        4'd7:  first_lane = LW'(3);
        4'd9:  first_lane = LW'(2);
        4'd10: first_lane = LW'(1);
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[LANES-1-g] = (LW'(g) >= first_lane) && (LW'(g) <= last_lane);
  end

  // Beat count: one below code 11, then groups of four doublewords.
  always_comb begin
    if (size_code < 4'd11) begin
      beats = CW'(1);
    end else if (size_code == 4'd11) begin
      beats = wptr ? CW'(2) : CW'(1);
    end else begin
      beats = CW'({size_code[1:0], 3'b100}) + (wptr ? CW'(4) : CW'(0));
    end
  end

endmodule

// File: rtl/ioreq_burst_engine.sv
module ioreq_burst_engine
  import ioreq_pkg::*;
#(
  parameter int AW    = 31,
  parameter int CW    = 6,
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_write,
  input  logic [AW-1:0]    start_adr,
  input  logic [CW-1:0]    start_beats,
  input  logic [LANES-1:0] start_lanes,
  input  logic             wb_ack,
  input  logic             wb_err,
  output logic             idle,
  output logic             wb_cyc,
  output logic             wb_stb,
  output logic             wb_we,
  output logic [AW-1:0]    wb_adr,
  output logic [LANES-1:0] wb_sel,
  output logic             pay_next,
  output logic             beat_done,
  output logic             burst_end,
  output logic             burst_fail
);

  eng_state_t    state;
  logic [CW-1:0] left;

  wire in_beat = (state == ENG_BEAT);

  assign idle       = (state == ENG_IDLE);
  assign beat_done  = in_beat && wb_ack && !wb_err;
  assign burst_fail = in_beat && wb_err;
  assign burst_end  = burst_fail || (beat_done && (left == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ENG_IDLE;
      wb_cyc   <= 1'b0;
      wb_stb   <= 1'b0;
      wb_we    <= 1'b0;
      wb_adr   <= '0;
      wb_sel   <= '0;
      left     <= '0;
      pay_next <= 1'b0;
    end else begin
      pay_next <= 1'b0;
      unique case (state)
        ENG_IDLE: begin
          if (start) begin
            wb_cyc <= 1'b1;
            wb_stb <= 1'b1;
            wb_we  <= start_write;
            wb_adr <= start_adr;
            wb_sel <= start_lanes;
            left   <= start_beats - CW'(1);
            state  <= ENG_BEAT;
          end
        end
        ENG_BEAT: begin
          if (wb_err) begin
            wb_cyc <= 1'b0;
            wb_stb <= 1'b0;
            state  <= ENG_IDLE;
          end else if (wb_ack) begin
            pay_next <= wb_we;
            wb_adr   <= wb_adr + AW'(1);
            wb_stb   <= 1'b0;
            if (left == '0) begin
              wb_cyc <= 1'b0;
              state  <= ENG_IDLE;
            end else begin
              left  <= left - CW'(1);
              state <= ENG_GAP;
            end
          end
        end
        ENG_GAP: begin
          wb_stb <= 1'b1;
          state  <= ENG_BEAT;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ioreq_resp_gen.sv
module ioreq_resp_gen
  import ioreq_pkg::*;
#(
  parameter int DW  = 64,
  parameter int IDW = 16,
  parameter int TW  = 8,
  parameter int CW  = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           start_write,
  input  logic           start_want,
  input  logic [TW-1:0]  start_tid,
  input  logic [IDW-1:0] start_src,
  input  logic [IDW-1:0] start_dst,
  input  logic           beat_done,
  input  logic           burst_end,
  input  logic           burst_fail,
  input  logic [DW-1:0]  rd_word,
  output logic           rsp_valid,
  output logic [3:0]     rsp_status,
  output logic [TW-1:0]  rsp_tid,
  output logic [IDW-1:0] rsp_src,
  output logic [IDW-1:0] rsp_dst,
  output logic [CW-1:0]  rsp_len,
  output logic           rsp_data_valid,
  output logic [DW-1:0]  rsp_data
);

  logic           wr_q;
  logic           want_q;
  logic [TW-1:0]  tid_q;
  logic [IDW-1:0] src_q;
  logic [IDW-1:0] dst_q;
  logic [CW-1:0]  got;

  wire take_word = beat_done && !wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      want_q <= 1'b0;
      tid_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      got    <= '0;
    end else if (start) begin
      wr_q   <= start_write;
      want_q <= start_want;
      tid_q  <= start_tid;
      src_q  <= start_src;
      dst_q  <= start_dst;
      got    <= '0;
    end else if (take_word) begin
      got <= got + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_data_valid <= 1'b0;
      rsp_data       <= '0;
    end else begin
      rsp_data_valid <= take_word;
      if (take_word) rsp_data <= rd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_status <= RSP_OK;
      rsp_tid    <= '0;
      rsp_src    <= '0;
      rsp_dst    <= '0;
      rsp_len    <= '0;
    end else begin
      rsp_valid <= burst_end && (!wr_q || want_q);
      if (burst_end) begin
        rsp_status <= burst_fail ? RSP_FAIL : RSP_OK;
        rsp_tid    <= tid_q;
        rsp_src    <= dst_q;
        rsp_dst    <= src_q;
        rsp_len    <= wr_q ? '0 : (got + (take_word ? CW'(1) : CW'(0)));
      end
    end
  end

endmodule

// File: rtl/ioreq_wb_master.sv
module ioreq_wb_master
  import ioreq_pkg::*;
#(
  parameter int AW        = 31,
  parameter int DW        = 64,
  parameter int IDW       = 16,
  parameter int TW        = 8,
  parameter int MAX_BEATS = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic           req_want_rsp,
  input  logic [3:0]     req_size,
  input  logic           req_wptr,
  input  logic [AW-1:0]  req_adr,
  input  logic [TW-1:0]  req_tid,
  input  logic [IDW-1:0] req_src,
  input  logic [IDW-1:0] req_dst,
  input  logic [DW-1:0]  pay_data,
  output logic           pay_next,
  output logic           wb_cyc,
  output logic           wb_stb,
  output logic           wb_we,
  output logic [AW-1:0]  wb_adr,
  output logic [DW/BYTES_PER_BEAT-1:0] wb_sel,
  output logic [DW-1:0]  wb_dat_o,
  input  logic [DW-1:0]  wb_dat_i,
  input  logic           wb_ack,
  input  logic           wb_err,
  output logic           rsp_valid,
  output logic [3:0]     rsp_status,
  output logic [TW-1:0]  rsp_tid,
  output logic [IDW-1:0] rsp_src,
  output logic [IDW-1:0] rsp_dst,
  output logic [$clog2(MAX_BEATS+1)-1:0] rsp_len,
  output logic           rsp_data_valid,
  output logic [DW-1:0]  rsp_data
);

  localparam int LANES = DW / BYTES_PER_BEAT;
  localparam int CW    = $clog2(MAX_BEATS + 1);

  logic             eng_idle;
  logic             start;
  logic [CW-1:0]    dec_beats;
  logic [LANES-1:0] dec_lanes;
  logic             beat_done;
  logic             burst_end;
  logic             burst_fail;

  assign req_ready = eng_idle;
  assign start     = req_valid && eng_idle;
  assign wb_dat_o  = pay_data;

  ioreq_size_decode #(
    .LANES (LANES),
    .CW    (CW)
  ) i_dec (
    .size_code (req_size),
    .wptr      (req_wptr),
    .beats     (dec_beats),
    .lanes     (dec_lanes)
  );

  ioreq_burst_engine #(
    .AW    (AW),
    .CW    (CW),
    .LANES (LANES)
  ) i_eng (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .start_write (req_write),
    .start_adr   (req_adr),
    .start_beats (dec_beats),
    .start_lanes (dec_lanes),
    .wb_ack      (wb_ack),
    .wb_err      (wb_err),
    .idle        (eng_idle),
    .wb_cyc      (wb_cyc),
    .wb_stb      (wb_stb),
    .wb_we       (wb_we),
    .wb_adr      (wb_adr),
    .wb_sel      (wb_sel),
    .pay_next    (pay_next),
    .beat_done   (beat_done),
    .burst_end   (burst_end),
    .burst_fail  (burst_fail)
  );

  ioreq_resp_gen #(
    .DW  (DW),
    .IDW (IDW),
    .TW  (TW),
    .CW  (CW)
  ) i_rsp (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .start_write    (req_write),
    .start_want     (req_want_rsp),
    .start_tid      (req_tid),
    .start_src      (req_src),
    .start_dst      (req_dst),
    .beat_done      (beat_done),
    .burst_end      (burst_end),
    .burst_fail     (burst_fail),
    .rd_word        (wb_dat_i),
    .rsp_valid      (rsp_valid),
    .rsp_status     (rsp_status),
    .rsp_tid        (rsp_tid),
    .rsp_src        (rsp_src),
    .rsp_dst        (rsp_dst),
    .rsp_len        (rsp_len),
    .rsp_data_valid (rsp_data_valid),
    .rsp_data       (rsp_data)
  );

endmodule

// File: rtl/ioreq_wb_master_chk.sv
module ioreq_wb_master_chk #(
  parameter int AW    = 31,
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             wb_cyc,
  input logic             wb_stb,
  input logic             wb_we,
  input logic [AW-1:0]    wb_adr,
  input logic [LANES-1:0] wb_sel,
  input logic             wb_ack,
  input logic             wb_err,
  input logic             rsp_valid
);

  assert_stb_in_cyc_R5: assert property (@(posedge clk) disable iff (rst)
    wb_stb |-> wb_cyc);

  assert_hold_beat_R5: assert property (@(posedge clk) disable iff (rst)
    (wb_stb && !wb_ack && !wb_err) |=>
      (wb_stb && $stable(wb_adr) && $stable(wb_sel) && $stable(wb_we)));

  assert_strobe_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (wb_stb && wb_ack) |=> !wb_stb);

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (wb_stb && wb_ack && !wb_err) |=> (wb_adr == $past(wb_adr) + AW'(1)));

  assert_lanes_fixed_R4: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && $past(wb_cyc)) |-> ($stable(wb_sel) && $stable(wb_we)));

  assert_err_abort_R9: assert property (@(posedge clk) disable iff (rst)
    (wb_stb && wb_err) |=> (!wb_cyc && req_ready));

  assert_busy_R10: assert property (@(posedge clk) disable iff (rst)
    wb_cyc |-> !req_ready);

  assert_rsp_at_end_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (req_ready && !wb_cyc));

endmodule

bind ioreq_wb_master ioreq_wb_master_chk #(
  .AW    (AW),
  .LANES (LANES)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .wb_cyc    (wb_cyc),
  .wb_stb    (wb_stb),
  .wb_we     (wb_we),
  .wb_adr    (wb_adr),
  .wb_sel    (wb_sel),
  .wb_ack    (wb_ack),
  .wb_err    (wb_err),
  .rsp_valid (rsp_valid)
);

// File: tb/test_ioreq_wb_master.sv
module test_ioreq_wb_master;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_want_rsp = 1'b0;
  logic [3:0]  req_size = '0;
  logic        req_wptr = 1'b0;
  logic [30:0] req_adr = '0;
  logic [7:0]  req_tid = '0;
  logic [15:0] req_src = '0;
  logic [15:0] req_dst = '0;
  logic [63:0] pay_data;
  logic        pay_next;
  logic        wb_cyc, wb_stb, wb_we;
  logic [30:0] wb_adr;
  logic [7:0]  wb_sel;
  logic [63:0] wb_dat_o;
  logic [63:0] wb_dat_i;
  logic        s_ack, s_err;
  logic        rsp_valid;
  logic [3:0]  rsp_status;
  logic [7:0]  rsp_tid;
  logic [15:0] rsp_src, rsp_dst;
  logic [5:0]  rsp_len;
  logic        rsp_data_valid;
  logic [63:0] rsp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0;
  int nerr = 0;

  // Bench state: counters written by the monitor, expectations by the sequencer.
  int beat_cnt = 0, rd_cnt = 0, rsp_cnt = 0, pop_cnt = 0;
  int beat_start = 0, rd_start = 0, pay_start = 0;
  int lat = 0, err_at = -1, wcnt = 0;
  int pay_idx = 0;
  logic [30:0] exp_base = '0;
  logic [7:0]  exp_sel = '0;
  logic        exp_we = 1'b0;

  function automatic logic [63:0] rd_word(input logic [30:0] a);
    return {1'b0, a, 1'b1, ~a};
  endfunction

  function automatic logic [63:0] pay_word(input int k);
    logic [31:0] u;
    u = 32'(k);
    return {u * 32'h9E3779B1, ~(u * 32'h7F4A7C15)};
  endfunction

  function automatic int e_beats(input int code, input int w);
    if (code < 11) return 1;
    if (code == 11) return 1 + w;
    return 4 * (2 * (code - 12) + 1 + w);
  endfunction

  function automatic logic [7:0] e_sel(input int code, input int w);
    int n, st;
    logic [7:0] m0;
    st = 0;
    case (code)
      0, 1, 2, 3: begin n = 1; st = code; end
      4: n = 2;
      6: begin n = 2; st = 2; end
      5: n = 3;
      8: n = 4;
      7: n = 5;
      9: n = 6;
      10: n = 7;
      default: n = 8;
    endcase
    m0 = 8'hFF << (8 - n);
    m0 = m0 >> st;
    if (w == 0 || code >= 11) return m0;
    if (code == 5 || code == 7 || code == 9 || code == 10) return 8'hFF >> (8 - n);
    return m0 >> 4;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  assign pay_data = pay_word(pay_idx);
  assign wb_dat_i = rd_word(wb_adr);

  ioreq_wb_master i_ioreq_wb_master (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_want_rsp(req_want_rsp),
    .req_size(req_size), .req_wptr(req_wptr), .req_adr(req_adr),
    .req_tid(req_tid), .req_src(req_src), .req_dst(req_dst),
    .pay_data(pay_data), .pay_next(pay_next),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_sel(wb_sel), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i),
    .wb_ack(s_ack), .wb_err(s_err),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_tid(rsp_tid),
    .rsp_src(rsp_src), .rsp_dst(rsp_dst), .rsp_len(rsp_len),
    .rsp_data_valid(rsp_data_valid), .rsp_data(rsp_data)
  );

  // Bus slave: ACK or ERR after lat wait cycles, one beat at a time.
  always @(posedge clk) begin
    if (rst) begin
      s_ack <= 1'b0; s_err <= 1'b0; wcnt <= 0;
    end else if (s_ack || s_err) begin
      s_ack <= 1'b0; s_err <= 1'b0; wcnt <= 0;
    end else if (wb_cyc && wb_stb) begin
      if (wcnt >= lat) begin
        if (err_at == beat_cnt - beat_start) s_err <= 1'b1;
        else s_ack <= 1'b1;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (rst) pay_idx <= 0;
    else if (pay_next) pay_idx <= pay_idx + 1;
  end

  // Monitor at falling edges.
  always @(negedge clk) begin
    if (!rst) begin
      if (wb_cyc && wb_stb && s_ack) begin
        int k;
        k = beat_cnt - beat_start;
        chk(wb_adr == exp_base + 31'(k), "R4 beat address", 64'(wb_adr), 64'(exp_base + 31'(k)));
        chk(wb_sel == exp_sel, "R2/R3 lanes", 64'(wb_sel), 64'(exp_sel));
        chk(wb_we == exp_we, "R4 direction", 64'(wb_we), 64'(exp_we));
        if (exp_we)
          chk(wb_dat_o == pay_word(pay_start + k), "R12 write data", wb_dat_o, pay_word(pay_start + k));
        beat_cnt++;
      end
      if (rsp_data_valid) begin
        int k;
        k = rd_cnt - rd_start;
        chk(rsp_data == rd_word(exp_base + 31'(k)), "R6 read word", rsp_data, rd_word(exp_base + 31'(k)));
        rd_cnt++;
      end
      if (rsp_valid) rsp_cnt++;
      if (pay_next) pop_cnt++;
    end
  end

  task automatic run_req(input bit wr, input bit want, input int code, input int w,
                         input logic [30:0] base, input logic [7:0] tid, input int err_beat);
    int nb, beats_before, rd_before, rsp_before, pop_before, acked;
    bit rsp_due;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 idle before request", 64'(req_ready), 64'd1);
    nb = e_beats(code, w);
    acked = (err_beat >= 0) ? err_beat : nb;
    rsp_due = !wr || want;
    exp_base = base; exp_sel = e_sel(code, w); exp_we = wr;
    beat_start = beat_cnt; rd_start = rd_cnt; pay_start = pay_idx;
    beats_before = beat_cnt; rd_before = rd_cnt; rsp_before = rsp_cnt; pop_before = pop_cnt;
    lat = (code + w + int'(wr) + int'(want)) % 3;
    err_at = err_beat;
    req_valid = 1'b1; req_write = wr; req_want_rsp = want;
    req_size = 4'(code); req_wptr = w[0]; req_adr = base; req_tid = tid;
    req_src = 16'hA000 + 16'(tid); req_dst = 16'h5000 + 16'(code);
    @(negedge clk);
    // Busy: a second request with another tag must be ignored (R10).
    chk(req_ready == 1'b0, "R10 busy after accept", 64'(req_ready), 64'd0);
    req_tid = tid ^ 8'hFF; req_adr = ~base;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    chk(wb_cyc == 1'b0, "R5 cycle closed at end", 64'(wb_cyc), 64'd0);
    chk(rsp_valid == rsp_due, "R6/R7/R8 response presence", 64'(rsp_valid), 64'(rsp_due));
    if (rsp_due) begin
      chk(rsp_status == ((err_beat >= 0) ? 4'b0111 : 4'b0000), "R6/R7/R9 status",
          64'(rsp_status), (err_beat >= 0) ? 64'd7 : 64'd0);
      chk(rsp_tid == tid, "R6 tag echo", 64'(rsp_tid), 64'(tid));
      chk(rsp_src == 16'h5000 + 16'(code), "R6 swapped source", 64'(rsp_src), 64'(16'h5000 + 16'(code)));
      chk(rsp_dst == 16'hA000 + 16'(tid), "R6 swapped dest", 64'(rsp_dst), 64'(16'hA000 + 16'(tid)));
      chk(rsp_len == (wr ? 6'd0 : 6'(acked)), "R6/R7/R9 length", 64'(rsp_len), wr ? 64'd0 : 64'(acked));
    end
    @(negedge clk);
    chk(beat_cnt - beats_before == acked, "R1/R9 beat count", 64'(beat_cnt - beats_before), 64'(acked));
    chk(rsp_cnt - rsp_before == int'(rsp_due), "R8 response count", 64'(rsp_cnt - rsp_before), 64'(rsp_due));
    chk(rd_cnt - rd_before == (wr ? 0 : acked), "R6/R7 read words", 64'(rd_cnt - rd_before), wr ? 64'd0 : 64'(acked));
    chk(pop_cnt - pop_before == (wr ? acked : 0), "R12 payload pops", 64'(pop_cnt - pop_before), wr ? 64'(acked) : 64'd0);
    err_at = -1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(req_ready == 1'b1, "R11 ready", 64'(req_ready), 64'd1);
    chk(wb_cyc == 1'b0 && wb_stb == 1'b0, "R11 bus idle", {wb_cyc, wb_stb}, 64'd0);
    chk(rsp_valid == 1'b0 && rsp_data_valid == 1'b0 && pay_next == 1'b0, "R11 strobes",
        {rsp_valid, rsp_data_valid, pay_next}, 64'd0);
    // R1 R2 R3: every size code and pointer, read, write with and without response.
    for (int kind = 0; kind < 3; kind++) begin
      for (int code = 0; code < 16; code++) begin
        for (int w = 0; w < 2; w++) begin
          run_req(kind != 0, kind == 1, code, w,
                  31'(code * 1000 + w * 17 + kind * 40000 + 5),
                  8'(code * 2 + w + kind * 64), -1);
        end
      end
    end
    // R9: error mid-burst for each request kind.
    run_req(1'b0, 1'b0, 15, 1, 31'h7FFF_0000, 8'hC1, 3);
    run_req(1'b1, 1'b1, 13, 0, 31'h0012_3400, 8'hC2, 5);
    run_req(1'b1, 1'b0, 12, 1, 31'h0000_0100, 8'hC3, 0);
    run_req(1'b0, 1'b0, 0, 0, 31'h0000_0200, 8'hC4, 0);
    // Recovery after errors.
    run_req(1'b0, 1'b0, 11, 1, 31'h7FFF_FFFF, 8'hC5, -1);
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule